// File: doc/BRIEF.md
# Pipelined fractional multiply-accumulate unit

This block is the arithmetic core of a fixed-point datapath. It takes two 24-bit data words each cycle and multiplies them. Either operand can be treated as signed two's complement or as unsigned. The product is placed in a 56-bit accumulator, added to it, or subtracted from it. There are two such accumulators, A and B, and each operation picks one. An accumulator is split into an 8-bit guard extension (bits 55:48), a high word (bits 47:24) and a low word (bits 23:0). Each operation can also request that the low word be rounded into the high word.

The pipeline has two stages. The first stage forms the aligned product and reads the source accumulator. The second stage adds or subtracts and optionally rounds. The new accumulator value is written back and presented on the outputs. A new operation can be issued on every clock. An operation that reads the accumulator written by the operation just before it gets the new value through a bypass path, so the pipeline never stalls. The 24-bit stored form of the result is the high word.

Top module: `fmac_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` is 0 after that edge. The edge clears both accumulators to zero, so a later MAC with a zero product returns 0.
- R2: With `sign_mode` = 2'b00, both operands are signed two's complement and the product is their signed product.
- R3: With `sign_mode` = 2'b01, `op_x` is signed and `op_y` is unsigned. With 2'b10 or 2'b11, both operands are unsigned.
- R4: With `frac_en` = 1, the product is shifted left by one bit before accumulation. With `frac_en` = 0, it is used unshifted. The aligned product is sign-extended to 56 bits.
- R5: With `opcode` 2'b01, the aligned product is added to the selected accumulator. With 2'b10, it is subtracted from it. With 2'b00 or 2'b11, the result is the product alone and the old accumulator value is ignored.
- R6: `acc_sel` 0 selects accumulator A and 1 selects accumulator B. An operation changes only the accumulator it selects. `out_sel` reports which accumulator was written.
- R7: An operation presented with `in_valid` high at clock edge k produces `out_valid` high, with its result, after edge k+1. Operations can be issued on consecutive cycles.
- R8: An operation that reads the accumulator written by the immediately preceding operation uses that operation's result, with no stall.
- R9: With `round_en` = 1, the result is rounded on bit 23 to the nearest value, with ties going to an even bit 24. The low 24 bits are then cleared. With `round_en` = 0, the low 24 bits are kept.
- R10: Accumulation wraps modulo 2^56. `out_word` always equals bits 47:24 of `out_acc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_x | input | 24 | First multiplier operand |
| op_y | input | 24 | Second multiplier operand |
| sign_mode | input | 2 | 00 signed x signed, 01 signed x unsigned, 1x unsigned x unsigned |
| acc_sel | input | 1 | Accumulator select: 0 = A, 1 = B |
| opcode | input | 2 | 00/11 multiply, 01 multiply-add, 10 multiply-subtract |
| frac_en | input | 1 | Fractional alignment (product shifted left by one) |
| round_en | input | 1 | Round low word into high word |
| out_valid | output | 1 | Result valid |
| out_sel | output | 1 | Accumulator that was written |
| out_acc | output | 56 | Full accumulator result |
| out_word | output | 24 | 24-bit stored form of the result (bits 47:24) |

## Verification
A wrong accumulator value is not confined to the operation that created it. Every later operation on the same accumulator carries the error, and the next `out_acc` for that accumulator shows it within two cycles. A broken bypass shows up only on back-to-back operations that read the same accumulator: the result is off by exactly the previous operation's contribution. A corrupted pipeline valid bit shows up as a result that arrives a cycle early or a cycle late, or as a missing result.

// File: rtl/fmac_pkg.sv
// Shared encodings for the multiply-accumulate unit.
// Assumes: opcode and sign-mode fields are 2 bits wide.
package fmac_pkg;
    typedef enum logic [1:0] {
        OP_MPY = 2'b00,
        OP_MAC = 2'b01,
        OP_MSU = 2'b10,
        OP_MPX = 2'b11
    } fmac_op_e;

    localparam logic [1:0] SM_SS = 2'b00;
    localparam logic [1:0] SM_SU = 2'b01;
endpackage

// File: rtl/fmac_mult.sv
// Stage-one multiplier: applies per-operand sign handling, forms the full product,
// optionally aligns it for fractional data and sign-extends to accumulator width.
// Assumes: AW >= 2*DW + 3 so the shifted product plus sign fits.
module fmac_mult #(
    parameter int DW = 24,
    parameter int AW = 56
) (
    input  logic [DW-1:0]  x,
    input  logic [DW-1:0]  y,
    input  logic [1:0]     smode,
    input  logic           frac,
    output logic [AW-1:0]  prod
);
    import fmac_pkg::*;

    localparam int PW = 2 * DW + 2;

    logic               x_signed;
    logic               y_signed;
    logic signed [PW-1:0] xe;
    logic signed [PW-1:0] ye;
    logic signed [PW-1:0] full;
    logic signed [PW:0]   shifted;

    // Decode operand signedness and extend both operands to product width.
    always_comb begin
        x_signed = (smode == SM_SS) || (smode == SM_SU);
        y_signed = (smode == SM_SS);
        xe = {{(PW-DW){x_signed & x[DW-1]}}, x};
        ye = {{(PW-DW){y_signed & y[DW-1]}}, y};
    end

    // Multiply, align and widen to accumulator size.
    always_comb begin
        full    = xe * ye;
        shifted = frac ? {full, 1'b0} : {full[PW-1], full};
        prod    = {{(AW-PW-1){shifted[PW]}}, shifted};
    end
endmodule

// File: rtl/fmac_accum.sv
// Stage-two arithmetic: combines the aligned product with the source accumulator
// by opcode, then optionally rounds the low word into the high word
// (nearest, ties to even on bit DW).
// Assumes: purely combinational; arithmetic wraps modulo 2^AW.
module fmac_accum #(
    parameter int DW = 24,
    parameter int AW = 56
) (
    input  logic [1:0]     op,
    input  logic           rnd,
    input  logic [AW-1:0]  src,
    input  logic [AW-1:0]  prod,
    output logic [AW-1:0]  res
);
    import fmac_pkg::*;

    logic [AW-1:0]    sum;
    logic [DW-1:0]    low;
    logic             bump;
    logic [AW-DW-1:0] hi;

    // Select plain multiply, add or subtract.
    always_comb begin
        unique case (fmac_op_e'(op))
            OP_MAC:  sum = src + prod;
            OP_MSU:  sum = src - prod;
            default: sum = prod;
        endcase
    end

    // Convergent rounding at bit DW-1, then clear the low word.
    always_comb begin
        low  = sum[DW-1:0];
        bump = low[DW-1] & ((|low[DW-2:0]) | sum[DW]);
        hi   = sum[AW-1:DW] + {{(AW-DW-1){1'b0}}, bump};
        res  = rnd ? {hi, {DW{1'b0}}} : sum;
    end
endmodule

// File: rtl/fmac_acc_bank.sv
// Accumulator register bank: NACC registers, one write port, one read port.
// Assumes: synchronous active-low reset clears every register.
module fmac_acc_bank #(
    parameter int NACC = 2,
    parameter int SW   = 1,
    parameter int AW   = 56
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [SW-1:0]  wsel,
    input  logic [AW-1:0]  wdata,
    input  logic [SW-1:0]  rsel,
    output logic [AW-1:0]  rdata
);
    logic [AW-1:0] acc_q [NACC];

    for (genvar i = 0; i < NACC; i++) begin : g_acc
        // Hold accumulator i; load on a write addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_q[i] <= '0;
            else if (we && (wsel == SW'(i)))
                acc_q[i] <= wdata;
        end
    end

    // Read port.
    always_comb rdata = acc_q[rsel];
endmodule

// File: rtl/fmac_core.sv
// Two-stage pipelined fractional multiply-accumulate unit with NACC accumulators.
// Stage 1 forms the aligned product and reads the source accumulator, bypassing
// the result still in stage 2 when it targets the same accumulator. Stage 2 adds,
// subtracts or passes the product, optionally rounds, and writes back.
// Assumes: one operation per cycle, no backpressure, synchronous active-low reset.
module fmac_core #(
    parameter int DW   = 24,
    parameter int EXT  = 8,
    parameter int NACC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DW-1:0]       op_x,
    input  logic [DW-1:0]       op_y,
    input  logic [1:0]          sign_mode,
    input  logic [((NACC > 1) ? $clog2(NACC) : 1)-1:0] acc_sel,
    input  logic [1:0]          opcode,
    input  logic                frac_en,
    input  logic                round_en,
    output logic                out_valid,
    output logic [((NACC > 1) ? $clog2(NACC) : 1)-1:0] out_sel,
    output logic [2*DW+EXT-1:0] out_acc,
    output logic [DW-1:0]       out_word
);
    import fmac_pkg::*;

    localparam int AW = 2 * DW + EXT;
    localparam int SW = (NACC > 1) ? $clog2(NACC) : 1;

    logic [AW-1:0] prod_in;
    logic [AW-1:0] bank_rd;
    logic [AW-1:0] src_in;
    logic [AW-1:0] res;
    logic          fwd_hit;

    logic          s1_vld;
    logic [SW-1:0] s1_sel;
    logic [1:0]    s1_op;
    logic          s1_rnd;
    logic [AW-1:0] s1_prod;
    logic [AW-1:0] s1_src;

    fmac_mult #(.DW(DW), .AW(AW)) u_mult (
        .x     (op_x),
        .y     (op_y),
        .smode (sign_mode),
        .frac  (frac_en),
        .prod  (prod_in)
    );

    fmac_acc_bank #(.NACC(NACC), .SW(SW), .AW(AW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (s1_vld),
        .wsel  (s1_sel),
        .wdata (res),
        .rsel  (acc_sel),
        .rdata (bank_rd)
    );

    // Bypass the stage-2 result when it targets the accumulator being read.
    always_comb begin
        fwd_hit = s1_vld && (s1_sel == acc_sel);
        src_in  = fwd_hit ? res : bank_rd;
    end

    // Stage-1 pipeline register: product, source and control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_sel  <= '0;
            s1_op   <= '0;
            s1_rnd  <= 1'b0;
            s1_prod <= '0;
            s1_src  <= '0;
        end else begin
            s1_vld  <= in_valid;
            s1_sel  <= acc_sel;
            s1_op   <= opcode;
            s1_rnd  <= round_en;
            s1_prod <= prod_in;
            s1_src  <= src_in;
        end
    end

    fmac_accum #(.DW(DW), .AW(AW)) u_accum (
        .op   (s1_op),
        .rnd  (s1_rnd),
        .src  (s1_src),
        .prod (s1_prod),
        .res  (res)
    );

    // Output register: full result and its stored 24-bit form.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sel   <= '0;
            out_acc   <= '0;
            out_word  <= '0;
        end else begin
            out_valid <= s1_vld;
            out_sel   <= s1_sel;
            out_acc   <= res;
            out_word  <= res[2*DW-1:DW];
        end
    end

    // R1: reset empties the pipeline.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !s1_vld));

    // R7: an issued operation reaches stage 2, then the output, one cycle each.
    assert_issue_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_vld);
    assert_result_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |=> out_valid);

    // R5: a plain multiply without rounding yields exactly the aligned product.
    assert_mpy_ignores_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && !s1_rnd && (s1_op == OP_MPY || s1_op == OP_MPX)) |-> (res == s1_prod));

    // R9: a rounded result has an empty low word.
    assert_round_clears_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_rnd) |-> (res[DW-1:0] == '0));

    // R10: the stored word tracks the middle field of the result.
    assert_word_field_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_word == out_acc[2*DW-1:DW]));
endmodule

// File: tb/sim_fmac_core.sv
`timescale 1ns/100ps
module sim_fmac_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] op_x = '0;
    logic [23:0] op_y = '0;
    logic [1:0]  sign_mode = '0;
    logic        acc_sel = 1'b0;
    logic [1:0]  opcode = '0;
    logic        frac_en = 1'b0;
    logic        round_en = 1'b0;
    logic        out_valid;
    logic        out_sel;
    logic [55:0] out_acc;
    logic [23:0] out_word;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic        sel;
        logic [55:0] acc;
        int          cyc;
        string       tag;
    } item_t;
    item_t sb[$];
    logic [55:0] model [2];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fmac_core u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_x(op_x), .op_y(op_y),
        .sign_mode(sign_mode), .acc_sel(acc_sel), .opcode(opcode),
        .frac_en(frac_en), .round_en(round_en), .out_valid(out_valid),
        .out_sel(out_sel), .out_acc(out_acc), .out_word(out_word)
    );

    // Reference arithmetic written from the requirements.
    function automatic logic [55:0] ref_op(logic [23:0] x, logic [23:0] y, logic [1:0] sm,
                                           logic [1:0] op, logic fr, logic rn, logic [55:0] a);
        logic signed [63:0] px, py, p;
        logic [55:0] r;
        logic [23:0] low;
        px = (sm == 2'b00 || sm == 2'b01) ? {{40{x[23]}}, x} : {40'b0, x};
        py = (sm == 2'b00) ? {{40{y[23]}}, y} : {40'b0, y};
        p  = px * py;
        if (fr) p = p <<< 1;
        case (op)
            2'b01:   r = a + p[55:0];
            2'b10:   r = a - p[55:0];
            default: r = p[55:0];
        endcase
        if (rn) begin
            low = r[23:0];
            if (low > 24'h800000 || (low == 24'h800000 && r[24])) r = r + 56'h1000000;
            r[23:0] = '0;
        end
        return r;
    endfunction

    // Driver: present one operation and push its expected result.
    task automatic issue(logic [23:0] x, logic [23:0] y, logic [1:0] sm, logic sel,
                         logic [1:0] op, logic fr, logic rn, string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; op_x = x; op_y = y; sign_mode = sm; acc_sel = sel;
        opcode = op; frac_en = fr; round_en = rn;
        model[sel] = ref_op(x, y, sm, op, fr, rn, model[sel]);
        it.sel = sel; it.acc = model[sel]; it.cyc = cyc + 2; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_x = 24'h5A5A5A;
        end
    endtask

    task automatic drain();
        idle(1);
        while (sb.size() != 0) @(negedge clk);
        idle(2);
    endtask

    // Monitor: compare each result as it appears.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                errors++; checks++;
                $display("FAIL R7 unexpected result acc=%h expected none", out_acc);
            end else begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (out_acc !== it.acc || out_sel !== it.sel) begin
                    errors++;
                    $display("FAIL %s acc=%h sel=%0d expected acc=%h sel=%0d",
                             it.tag, out_acc, out_sel, it.acc, it.sel);
                end
                checks++;
                if (out_word !== it.acc[47:24]) begin
                    errors++;
                    $display("FAIL R10 word=%h expected %h", out_word, it.acc[47:24]);
                end
                checks++;
                if (cyc != it.cyc) begin
                    errors++;
                    $display("FAIL R7 result cycle=%0d expected %0d", cyc, it.cyc);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 out_valid=%b expected 0", out_valid);
        end
        model[0] = '0; model[1] = '0;
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        model[0] = '0; model[1] = '0;
        do_reset();
        // R1: cleared accumulators
        issue(24'h0, 24'h0, 2'b00, 1'b0, 2'b01, 1'b0, 1'b0, "R1");
        issue(24'h0, 24'h0, 2'b00, 1'b1, 2'b01, 1'b0, 1'b0, "R1");
        drain();
        // R2 / R4: signed fractional and integer
        issue(24'h400000, 24'hC00000, 2'b00, 1'b0, 2'b00, 1'b1, 1'b0, "R2_R4");
        issue(24'hFFFFFF, 24'hFFFFFF, 2'b00, 1'b1, 2'b00, 1'b0, 1'b0, "R2");
        issue(24'h800000, 24'h800000, 2'b00, 1'b1, 2'b00, 1'b1, 1'b0, "R2_R4");
        issue(24'h123456, 24'h654321, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, "R4");
        // R3: mixed and unsigned
        issue(24'hFFFFFF, 24'hFFFFFF, 2'b01, 1'b0, 2'b00, 1'b0, 1'b0, "R3");
        issue(24'hFFFFFF, 24'hFFFFFF, 2'b10, 1'b1, 2'b00, 1'b0, 1'b0, "R3");
        issue(24'h800000, 24'h800000, 2'b11, 1'b1, 2'b00, 1'b1, 1'b0, "R3");
        drain();
        // R5: add, subtract, plain multiply ignoring old value
        issue(24'h300000, 24'h200000, 2'b00, 1'b0, 2'b00, 1'b1, 1'b0, "R5");
        idle(3);
        issue(24'h100000, 24'h100000, 2'b00, 1'b0, 2'b01, 1'b1, 1'b0, "R5");
        idle(2);
        issue(24'h7FFFFF, 24'h7FFFFF, 2'b00, 1'b0, 2'b10, 1'b1, 1'b0, "R5");
        idle(2);
        issue(24'h000003, 24'h000005, 2'b00, 1'b0, 2'b11, 1'b0, 1'b0, "R5");
        idle(2);
        issue(24'h000007, 24'h000002, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, "R5");
        drain();
        // R6: B activity leaves A intact (A read back with zero product)
        issue(24'h111111, 24'h222222, 2'b10, 1'b1, 2'b01, 1'b0, 1'b0, "R6");
        issue(24'h333333, 24'h444444, 2'b10, 1'b1, 2'b10, 1'b1, 1'b0, "R6");
        issue(24'h0, 24'h0, 2'b00, 1'b0, 2'b01, 1'b0, 1'b0, "R6");
        drain();
        // R8: back-to-back dependent operations, alternating and same target
        for (int i = 0; i < 12; i++)
            issue(24'h010203 * (i + 1), 24'h7000F1 - i, 2'b00, 1'b0, (i % 3 == 2) ? 2'b10 : 2'b01,
                  1'b1, 1'b0, "R8");
        for (int i = 0; i < 12; i++)
            issue(24'hABCDEF + i, 24'h00FF00, 2'b01, i[0], 2'b01, 1'b0, 1'b0, "R8");
        drain();
        // R9: rounding ties to even, above half, below half, truncation
        issue(24'h800000, 24'h000001, 2'b10, 1'b0, 2'b00, 1'b0, 1'b1, "R9");
        issue(24'hC00000, 24'h000002, 2'b10, 1'b0, 2'b00, 1'b0, 1'b1, "R9");
        issue(24'h800001, 24'h000001, 2'b10, 1'b1, 2'b00, 1'b0, 1'b1, "R9");
        issue(24'h7FFFFF, 24'h000001, 2'b10, 1'b1, 2'b00, 1'b0, 1'b1, "R9");
        issue(24'h812345, 24'h000003, 2'b10, 1'b1, 2'b01, 1'b0, 1'b0, "R9");
        issue(24'h400000, 24'hC00001, 2'b00, 1'b0, 2'b01, 1'b1, 1'b1, "R9");
        drain();
        // R10: wrap-around through repeated large accumulation
        issue(24'h0, 24'h0, 2'b00, 1'b1, 2'b00, 1'b0, 1'b0, "R10");
        for (int i = 0; i < 300; i++)
            issue(24'hFFFFFF, 24'hFFFFFF, 2'b10, 1'b1, 2'b01, 1'b1, 1'b0, "R10");
        drain();
        // Mixed stream with gaps
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            issue($urandom, $urandom, r[1:0], r[2], r[4:3], r[5], r[6], "R2_R5_R8_R9");
            if (r[9:7] == 3'd0) idle(int'(r[11:10]));
        end
        drain();
        // R1: reset mid-run clears both accumulators
        issue(24'h7FFFFF, 24'h7FFFFF, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, "R1");
        issue(24'h7FFFFF, 24'h7FFFFF, 2'b00, 1'b1, 2'b00, 1'b0, 1'b0, "R1");
        drain();
        do_reset();
        issue(24'h0, 24'h0, 2'b00, 1'b0, 2'b01, 1'b0, 1'b0, "R1");
        issue(24'h0, 24'h0, 2'b00, 1'b1, 2'b01, 1'b0, 1'b0, "R1");
        drain();
        finish_run();
    end

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired, pending=%0d expected 0", sb.size());
            finish_run();
        end
    end
endmodule